// File: doc/BRIEF.md
# Pattern Fill and Verify Sequencer

This block runs a hardware memory self-test through a 32-bit synchronous memory port. When it is started, it takes a base word address, a length in words and a mode bit. It then applies seven data patterns one after the other. For each pattern it first writes every word of the range. It then reads every word back and compares it with the value it expects. It stops at the first word that reads back wrong.

Full mode covers the whole range. Region mode covers only two short windows at each block boundary. Each block is 2^BLK_SHIFT words (one 1 MiB block with 32-bit words at the default setting). The windows are WIN_WORDS long (2 KiB at the default setting). The first window starts at the beginning of each block and the second ends at the end of it. Each window runs the full pattern list on its own.

While the test runs, the block drives a periodic keep-alive pulse, so that an external watchdog is not starved during long passes. At the end, a single done pulse reports pass or fail. On a failure, the block keeps the failing address, the expected word and the word that was read.

Top module: `pattern_sweep_seq`

## Requirements
- R1: Patterns are applied in this fixed order: 0x00000000, 0xFFFFFFFF, 0x55555555, 0xAAAAAAAA, one-hot `1 << (k mod 32)`, `k` zero-extended to 32 bits, and `~k`. Here k is the word index inside the range or window being tested.
- R2: For each pattern there are two passes. The write pass writes every word at ascending addresses, one write per cycle. The read pass that follows reads every word at ascending addresses, with at most one read outstanding. No new request is issued in the cycle after a read request.
- R3: The block compares each returned word with the expected pattern value. On the first mismatch it captures the address, the expected word and the read word, ends the test with pass low and issues no further memory access. Later patterns and windows are not run. The captured values hold until the next start.
- R4: In full mode (`full_mode`=1) the tested range is `len` words starting at `base`, and every access falls inside it.
- R5: In region mode (`full_mode`=0) the number of blocks is `len >> BLK_SHIFT`. For block b in ascending order, the block tests WIN_WORDS words starting at `base + b*2^BLK_SHIFT`. It then tests WIN_WORDS words starting at `base + (b+1)*2^BLK_SHIFT - WIN_WORDS`. Words outside these windows are never accessed.
- R6: The index k restarts at zero at the start of every window and of every full range. It is not taken from the absolute address.
- R7: `keepalive` pulses high in these cycles:
  - every write issue and every read issue whose index k is a multiple of 2^KA_SHIFT;
  - one cycle after the read pass of every pattern.
- R8: `done` is high for exactly one cycle at the end of a test, with `pass` high only if every compare matched. A zero-length full range, or a region-mode range shorter than one block, ends at once with pass high and no memory access.
- R9: After reset, `mem_req`, `done`, `pass` and `keepalive` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a test; sampled while idle |
| full_mode | input | 1 | 1: whole range, 0: boundary windows only |
| base | input | AW | First word address of the range |
| len | input | AW | Range length in words |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data returned (one or more cycles after the read request) |
| keepalive | output | 1 | Periodic pulse for an external watchdog |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | Test result, valid with done |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | 32 | Expected word at the first mismatch |
| fail_got | output | 32 | Word read at the first mismatch |

## Verification
The in-line assertions check the following on every cycle:
- `done` lasts one cycle;
- a read request is followed by an idle cycle;
- consecutive writes step the address by one;
- full-mode accesses stay within the range;
- pass falls only on a returned read;
- the captured failure fields hold while idle.

Only the bench scenarios can show the rest:
- the pattern order and values;
- the per-window restart of the index;
- the exact placement of the region windows;
- the keep-alive count;
- which mismatch is captured under stuck-bit and aliasing faults, and that nothing runs after it.

The bench reaches these by comparing each run's complete write stream against a sequence computed in the bench.

// File: rtl/pattern_sweep_seq.sv
module pattern_sweep_seq #(
  parameter int AW        = 32,
  parameter int BLK_SHIFT = 18,
  parameter int WIN_WORDS = 512,
  parameter int KA_SHIFT  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          full_mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_rvalid,
  output logic          keepalive,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fail_addr,
  output logic [31:0]   fail_exp,
  output logic [31:0]   fail_got
);

  localparam logic [AW-1:0] BLK_WORDS = AW'(1) << BLK_SHIFT;
  localparam logic [AW-1:0] WIN_LEN   = AW'(WIN_WORDS);
  localparam logic [AW-1:0] WIN2_OFF  = BLK_WORDS - WIN_LEN;
  localparam logic [2:0]    LAST_PAT  = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_WAIT, S_NEXT, S_DONE} st_t;

  st_t           st;
  logic [2:0]    pat;
  logic [AW-1:0] idx, blk, base_r, len_r;
  logic          sel, full_r, pass_r;

  logic [AW-1:0] nblk, win_base, win_len;
  logic [31:0]   idx32, pat_val;
  logic          last_idx, last_win, empty;

  assign nblk     = len_r >> BLK_SHIFT;
  assign win_base = full_r ? base_r : base_r + (blk << BLK_SHIFT) + (sel ? WIN2_OFF : '0);
  assign win_len  = full_r ? len_r : WIN_LEN;
  assign last_idx = (idx == win_len - 1'b1);
  assign last_win = full_r || (sel && blk == nblk - 1'b1);
  assign empty    = full_mode ? (len == '0) : ((len >> BLK_SHIFT) == '0);
  assign idx32    = 32'(idx);

  always_comb begin
    case (pat)
      3'd0:    pat_val = 32'h0000_0000;
      3'd1:    pat_val = 32'hFFFF_FFFF;
      3'd2:    pat_val = 32'h5555_5555;
      3'd3:    pat_val = 32'hAAAA_AAAA;
      3'd4:    pat_val = 32'd1 << idx32[4:0];
      3'd5:    pat_val = idx32;
      default: pat_val = ~idx32;
    endcase
  end

  assign mem_req   = (st == S_WR) || (st == S_RD);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = win_base + idx;
  assign mem_wdata = pat_val;
  assign keepalive = (mem_req && idx[KA_SHIFT-1:0] == '0) || (st == S_NEXT);
  assign done      = (st == S_DONE);
  assign pass      = pass_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pat <= '0; idx <= '0; blk <= '0; sel <= 1'b0;
      full_r <= 1'b0; base_r <= '0; len_r <= '0; pass_r <= 1'b0;
      fail_addr <= '0; fail_exp <= '0; fail_got <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          full_r <= full_mode; base_r <= base; len_r <= len;
          pat <= '0; idx <= '0; blk <= '0; sel <= 1'b0; pass_r <= 1'b1;
          st <= empty ? S_DONE : S_WR;
        end
        S_WR: begin
          if (last_idx) begin idx <= '0; st <= S_RD; end
          else idx <= idx + 1'b1;
        end
        S_RD: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (mem_rdata != pat_val) begin
            fail_addr <= mem_addr; fail_exp <= pat_val; fail_got <= mem_rdata;
            pass_r <= 1'b0; st <= S_DONE;
          end else if (last_idx) st <= S_NEXT;
          else begin idx <= idx + 1'b1; st <= S_RD; end
        end
        S_NEXT: begin
          idx <= '0;
          st  <= S_WR;
          if (pat == LAST_PAT) begin
            pat <= '0;
            if (last_win) st <= S_DONE;
            else if (sel) begin sel <= 1'b0; blk <= blk + 1'b1; end
            else sel <= 1'b1;
          end else pat <= pat + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_READ_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !mem_req); // R2
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req && mem_we)) |-> mem_addr == $past(mem_addr) + 1'b1); // R2
  AST_FULL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && full_r) |-> (mem_addr - base_r) < len_r); // R4
  AST_FAIL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pass_r) |-> $past(mem_rvalid)); // R3
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start) |=> $stable(fail_addr) && $stable(fail_exp) && $stable(fail_got)); // R3

endmodule

// File: tb/tb_pattern_sweep_seq.sv
module tb_pattern_sweep_seq;
  localparam int AW = 16, BS = 6, WIN = 8, KS = 4;

  logic clk = 0, rst_n = 0, start = 0, full_mode = 0;
  logic [AW-1:0] base = '0, len = '0;
  logic mem_req, mem_we, mem_rvalid, keepalive, done, pass;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [31:0] mem_wdata, mem_rdata, fail_exp, fail_got;

  always #4 clk = ~clk;

  pattern_sweep_seq #(.AW(AW), .BLK_SHIFT(BS), .WIN_WORDS(WIN), .KA_SHIFT(KS)) dut (
    .clk, .rst_n, .start, .full_mode, .base, .len, .mem_req, .mem_we, .mem_addr,
    .mem_wdata, .mem_rdata, .mem_rvalid, .keepalive, .done, .pass,
    .fail_addr, .fail_exp, .fail_got);

  logic [31:0] mem [256];
  int stuck_addr = -1;
  logic [31:0] set1 = '0, clr0 = '0;
  bit alias_en = 0;

  function automatic int phys(logic [AW-1:0] a);
    return alias_en ? int'(a[7:0] & 8'hF7) : int'(a[7:0]);
  endfunction

  always_ff @(posedge clk) begin
    mem_rvalid <= mem_req && !mem_we;
    if (mem_req && mem_we) mem[phys(mem_addr)] <= mem_wdata;
    if (mem_req && !mem_we) begin
      if (phys(mem_addr) == stuck_addr) mem_rdata <= (mem[phys(mem_addr)] | set1) & ~clr0;
      else mem_rdata <= mem[phys(mem_addr)];
    end
  end

  int checks = 0, failures = 0, cycles = 0;
  int wr_cnt, rd_cnt, ka_cnt, seq_err, exp_n;
  logic [AW-1:0] exp_a [1024];
  logic [31:0]   exp_d [1024];

  function automatic logic [31:0] pv(int p, int k);
    case (p)
      0: return 32'h0; 1: return 32'hFFFFFFFF; 2: return 32'h55555555; 3: return 32'hAAAAAAAA;
      4: return 32'd1 << (k % 32); 5: return 32'(k); default: return ~32'(k);
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic add_window(int wb, int wl);
    for (int p = 0; p < 7; p++)
      for (int k = 0; k < wl; k++) begin
        exp_a[exp_n] = AW'(wb + k); exp_d[exp_n] = pv(p, k); exp_n++;
      end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (keepalive) ka_cnt++;
      if (mem_req && !mem_we) rd_cnt++;
      if (mem_req && mem_we) begin
        if (wr_cnt >= exp_n || mem_addr != exp_a[wr_cnt] || mem_wdata != exp_d[wr_cnt]) seq_err++;
        wr_cnt++;
      end
    end
    if (cycles > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(bit fm, int b, int l);
    wr_cnt = 0; rd_cnt = 0; ka_cnt = 0; seq_err = 0;
    @(negedge clk);
    full_mode = fm; base = AW'(b); len = AW'(l); start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check(!done, "R8", "done width", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!mem_req && !done && !pass && !keepalive, "R9", "reset outputs",
          {mem_req, done, pass, keepalive}, 0);
    rst_n = 1;

    // R1 R2 R4 R6 R7: full range, clean memory
    exp_n = 0; add_window(100, 40);
    run(1, 100, 40);
    check(pass, "R8", "full pass", pass, 1);
    check(wr_cnt == 280 && seq_err == 0, "R1", "full write stream", seq_err, 0);
    check(rd_cnt == 280, "R2", "full read count", rd_cnt, 280);
    check(ka_cnt == 49, "R7", "full keepalive count", ka_cnt, 49);

    // R5 R6: region mode, three blocks
    exp_n = 0;
    for (int b = 0; b < 3; b++) begin add_window(b*64, WIN); add_window(b*64 + 56, WIN); end
    run(0, 0, 192);
    check(pass, "R5", "region pass", pass, 1);
    check(wr_cnt == 336 && seq_err == 0, "R5", "region write stream", seq_err, 0);
    check(ka_cnt == 126, "R7", "region keepalive count", ka_cnt, 126);

    // R5: fault outside windows is not seen
    stuck_addr = 30; set1 = 32'h1;
    run(0, 0, 192);
    check(pass, "R5", "fault outside windows", pass, 1);

    // R3: stuck bit inside second window
    stuck_addr = 60;
    run(0, 0, 192);
    check(!pass, "R3", "region fault pass", pass, 0);
    check(fail_addr == 60 && fail_exp == 0 && fail_got == 1, "R3", "region fault addr", fail_addr, 60);
    check(wr_cnt == 64, "R3", "region stops", wr_cnt, 64);

    // R3: stuck-low bit 31, full mode
    stuck_addr = 105; set1 = 0; clr0 = 32'h8000_0000;
    exp_n = 0; add_window(100, 40);
    run(1, 100, 40);
    check(!pass && fail_addr == 105, "R3", "stuck low addr", fail_addr, 105);
    check(fail_exp == 32'hFFFFFFFF && fail_got == 32'h7FFFFFFF, "R1", "stuck low data", fail_got, 32'h7FFFFFFF);
    check(wr_cnt == 80 && rd_cnt == 46 && seq_err == 0, "R3", "no access after fail", rd_cnt, 46);
    repeat (4) @(negedge clk);
    check(fail_addr == 105 && !pass, "R3", "fail fields held", fail_addr, 105);

    // R6 R1: address aliasing seen first by the one-hot pattern
    stuck_addr = -1; clr0 = 0; alias_en = 1;
    exp_n = 0; add_window(0, 16);
    run(1, 0, 16);
    check(!pass && fail_addr == 0 && fail_exp == 1 && fail_got == 32'h100, "R6", "alias one-hot",
          fail_got, 32'h100);
    check(wr_cnt == 80, "R1", "alias pattern index", wr_cnt, 80);
    alias_en = 0;

    // R8: empty ranges
    run(1, 0, 0);
    check(pass && wr_cnt == 0 && rd_cnt == 0, "R8", "empty full", wr_cnt, 0);
    run(0, 0, 50);
    check(pass && wr_cnt == 0 && rd_cnt == 0, "R8", "short region", wr_cnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule